// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block puts a small processor core to sleep and brings it back. Software programs an 8-bit control register holding a sleep-enable flag and a 3-bit mode field. The core raises a one-cycle strobe when it executes its sleep instruction. If the flag is set and the selected mode is legal, the block halts the core. It then drops the clock-domain enables that the chosen mode turns off. The clock gating cells, the oscillator and the interrupt controller sit outside the block and act on these enables.

An enabled interrupt wakes the block. It first spends a start-up interval with the oscillator forced on. The interval is zero, a short fixed count or a programmable count, depending on the mode. After that it holds the core halted for a fixed four cycles with all clocks running. It then releases the core and pulses a wake-complete flag. The core then services the interrupt and resumes after the sleep instruction. The hardware never clears the sleep-enable flag.

A reset during sleep returns the block to the running state and clears the register. Because of that, the core restarts from its reset vector.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: While rst_ni is low and just after it is released, cfg_rdata_o is 0, halt_o is 0, wake_done_o is 0 and all five clock enables are 1.
- R2: A write with cfg_we_i stores all 8 bits of cfg_wdata_i, and cfg_rdata_o shows them from the next cycle. Bit 7 is the sleep-enable flag, bits 6:4 are the mode code and bits 3:0 are plain storage. Without a write the register holds its value.
- R3: A sleep strobe while bit 7 is 0 is ignored, and halt_o stays 0.
- R4: A sleep strobe while running, with bit 7 at 1 and a legal mode, raises halt_o in the next cycle.
- R5: The mode codes 3'b100 and 3'b101 are reserved. A strobe with either code is ignored.
- R6: The codes 3'b110 (standby) and 3'b111 (extended standby) take effect only when xtal_sel_i is 1. Otherwise the strobe is ignored.
- R7: While asleep, the enables {cpu,io,adc,tmr,osc} are 01111 for idle (000), 00111 for ADC noise reduction (001), 00000 for power-down (010), 00010 for power-save (011), 00001 for standby (110) and 00011 for extended standby (111).
- R8: After the clock edge that samples irq_wake_i high during sleep, halt_o stays high for S+4 cycles. S is 0 for idle and ADC noise reduction, 6 for both standby modes, and the value of startup_cycles_i for power-down and power-save.
- R9: wake_done_o is a single-cycle pulse in the first cycle in which halt_o is low again after a wake.
- R10: irq_wake_i has no effect while running, and a sleep strobe has no effect while halted.
- R11: The hardware never clears the sleep-enable flag. A second strobe after a wake, with the flag still 1, enters sleep again.
- R12: During start-up osc_en_o is 1. During the four halt cycles, and at any time while running, all five enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register contents |
| sleep_strobe_i | input | 1 | One-cycle sleep instruction strobe |
| xtal_sel_i | input | 1 | External crystal is the clock source |
| irq_wake_i | input | 1 | Enabled interrupt pending |
| startup_cycles_i | input | CNT_W | Start-up delay for power-down and power-save |
| halt_o | output | 1 | Core halted |
| clk_cpu_en_o | output | 1 | CPU clock enable |
| clk_io_en_o | output | 1 | I/O peripheral clock enable |
| clk_adc_en_o | output | 1 | ADC clock enable |
| clk_tmr_en_o | output | 1 | Asynchronous timer clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| wake_done_o | output | 1 | Wake sequence complete pulse |

## Verification
The bench targets these corner cases:
- Reserved codes and crystal-only modes without a crystal. A design that decoded them would halt a core that has no way back.
- A start-up count of zero in power-down. A design that loaded it blindly would wrap the counter and stall for thousands of cycles.
- The exact S+4 halt length for each mode class. An off-by-one in either the start-up counter or the halt counter changes this length.
- Interrupts during run and strobes during sleep. A design that obeyed them would halt spuriously or restart sleep.
- A repeated strobe after a wake. A design that cleared the flag itself would fail to sleep the second time.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'b000,
    MODE_ADCNR = 3'b001,
    MODE_PDOWN = 3'b010,
    MODE_PSAVE = 3'b011,
    MODE_RSV4  = 3'b100,
    MODE_RSV5  = 3'b101,
    MODE_STBY  = 3'b110,
    MODE_XSTBY = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_STARTUP,
    ST_HALT
  } state_e;

  // start-up source per mode
  typedef enum logic [1:0] {
    SU_NONE,
    SU_SHORT,
    SU_FULL
  } su_e;

  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic tmr;
    logic osc;
  } dom_t;

  localparam dom_t DOM_ALL  = 5'b11111;
  localparam dom_t DOM_NONE = 5'b00000;

endpackage

// File: rtl/sleep_cfg_reg.sv
module sleep_cfg_reg #(
  parameter int W        = 8,
  parameter int SE_BIT   = 7,
  parameter int MODE_LSB = 4,
  parameter int MODE_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      q_o,
  output logic              se_o,
  output logic [MODE_W-1:0] mode_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= wdata_i;
  end

  assign q_o    = q_q;
  assign se_o   = q_q[SE_BIT];
  assign mode_o = q_q[MODE_LSB +: MODE_W];

endmodule

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
  import sleep_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       xtal_i,
  output logic       valid_o,
  output dom_t       dom_o,
  output su_e        su_o
);

  always_comb begin
    valid_o = 1'b1;
    dom_o   = DOM_NONE;
    su_o    = SU_FULL;
    unique case (mode_e'(mode_i))
      MODE_IDLE: begin
        dom_o = 5'b01111;
        su_o  = SU_NONE;
      end
      MODE_ADCNR: begin
        dom_o = 5'b00111;
        su_o  = SU_NONE;
      end
      MODE_PDOWN: dom_o = 5'b00000;
      MODE_PSAVE: dom_o = 5'b00010;
      MODE_STBY: begin
        dom_o   = 5'b00001;
        su_o    = SU_SHORT;
        valid_o = xtal_i;
      end
      MODE_XSTBY: begin
        dom_o   = 5'b00011;
        su_o    = SU_SHORT;
        valid_o = xtal_i;
      end
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STBY_CYCLES = 6,
  parameter int HALT_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             se_i,
  input  logic             valid_i,
  input  logic [2:0]       mode_i,
  input  logic             irq_i,
  input  su_e              su_i,
  input  logic [CNT_W-1:0] startup_i,
  output state_e           state_o,
  output logic [2:0]       mode_q_o,
  output logic             wake_done_o
);

  localparam logic [CNT_W-1:0] HALT_LD = CNT_W'(HALT_CYCLES - 1);
  localparam logic [CNT_W-1:0] STBY_LD = CNT_W'(STBY_CYCLES);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       mode_q, mode_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (strobe_i && se_i && valid_i) begin
          state_d = ST_SLEEP;
          mode_d  = mode_i;
        end
      end
      ST_SLEEP: begin
        if (irq_i) begin
          unique case (su_i)
            SU_SHORT: begin
              state_d = ST_STARTUP;
              cnt_d   = STBY_LD;
            end
            SU_FULL: begin
              if (startup_i == '0) begin
                state_d = ST_HALT;
                cnt_d   = HALT_LD;
              end else begin
                state_d = ST_STARTUP;
                cnt_d   = startup_i;
              end
            end
            default: begin
              state_d = ST_HALT;
              cnt_d   = HALT_LD;
            end
          endcase
        end
      end
      ST_STARTUP: begin
        if (cnt_q == CNT_W'(1)) begin
          state_d = ST_HALT;
          cnt_d   = HALT_LD;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_HALT: begin
        if (cnt_q == '0) begin
          state_d = ST_RUN;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      mode_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
    end
  end

  assign state_o     = state_q;
  assign mode_q_o    = mode_q;
  assign wake_done_o = done_q;

endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import sleep_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STBY_CYCLES = 6,
  parameter int HALT_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  input  logic             sleep_strobe_i,
  input  logic             xtal_sel_i,
  input  logic             irq_wake_i,
  input  logic [CNT_W-1:0] startup_cycles_i,
  output logic             halt_o,
  output logic             clk_cpu_en_o,
  output logic             clk_io_en_o,
  output logic             clk_adc_en_o,
  output logic             clk_tmr_en_o,
  output logic             osc_en_o,
  output logic             wake_done_o
);

  logic       se;
  logic [2:0] mode_cfg, mode_held;
  logic       entry_valid, held_valid;
  dom_t       entry_dom, held_dom, dom;
  su_e        entry_su, held_su;
  state_e     state;

  sleep_cfg_reg #(.W(8), .SE_BIT(7), .MODE_LSB(4), .MODE_W(3)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .q_o     (cfg_rdata_o),
    .se_o    (se),
    .mode_o  (mode_cfg)
  );

  // legality check of the programmed mode at entry
  sleep_mode_decode u_dec_entry (
    .mode_i  (mode_cfg),
    .xtal_i  (xtal_sel_i),
    .valid_o (entry_valid),
    .dom_o   (entry_dom),
    .su_o    (entry_su)
  );

  // domains and start-up source of the mode latched at entry
  sleep_mode_decode u_dec_held (
    .mode_i  (mode_held),
    .xtal_i  (1'b1),
    .valid_o (held_valid),
    .dom_o   (held_dom),
    .su_o    (held_su)
  );

  sleep_fsm #(
    .CNT_W       (CNT_W),
    .STBY_CYCLES (STBY_CYCLES),
    .HALT_CYCLES (HALT_CYCLES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (sleep_strobe_i),
    .se_i        (se),
    .valid_i     (entry_valid),
    .mode_i      (mode_cfg),
    .irq_i       (irq_wake_i),
    .su_i        (held_su),
    .startup_i   (startup_cycles_i),
    .state_o     (state),
    .mode_q_o    (mode_held),
    .wake_done_o (wake_done_o)
  );

  always_comb begin
    unique case (state)
      ST_SLEEP:   dom = held_dom;
      ST_STARTUP: dom = held_dom | dom_t'(5'b00001);
      default:    dom = DOM_ALL;
    endcase
  end

  assign halt_o       = (state != ST_RUN);
  assign clk_cpu_en_o = dom.cpu;
  assign clk_io_en_o  = dom.io;
  assign clk_adc_en_o = dom.adc;
  assign clk_tmr_en_o = dom.tmr;
  assign osc_en_o     = dom.osc;

  logic unused;
  assign unused = held_valid ^ (^entry_dom) ^ (^entry_su);

endmodule

// File: rtl/sleep_pwr_ctrl_chk.sv
module sleep_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [7:0] cfg_rdata_o,
  input logic       sleep_strobe_i,
  input logic       irq_wake_i,
  input logic       halt_o,
  input logic       clk_cpu_en_o,
  input logic       clk_io_en_o,
  input logic       clk_adc_en_o,
  input logic       clk_tmr_en_o,
  input logic       osc_en_o,
  input logic       wake_done_o
);

  assert_hold_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_rdata_o));

  assert_se_clear_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && sleep_strobe_i && !cfg_rdata_o[7]) |=> !halt_o);

  assert_reserved_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && sleep_strobe_i && cfg_rdata_o[6:5] == 2'b10) |=> !halt_o);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> !wake_done_o);

  assert_done_running_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> !halt_o);

  assert_release_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && $past(halt_o)) |-> wake_done_o);

  assert_irq_in_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && irq_wake_i && !sleep_strobe_i) |=> !halt_o);

  assert_run_clocks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_o |-> (clk_cpu_en_o && clk_io_en_o && clk_adc_en_o && clk_tmr_en_o && osc_en_o));

endmodule

bind sleep_pwr_ctrl sleep_pwr_ctrl_chk u_chk (.*);

// File: tb/tb_sleep_pwr_ctrl.sv
module tb_sleep_pwr_ctrl;

  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [7:0]       cfg_wdata_i = '0;
  logic [7:0]       cfg_rdata_o;
  logic             sleep_strobe_i = 1'b0;
  logic             xtal_sel_i = 1'b0;
  logic             irq_wake_i = 1'b0;
  logic [CNT_W-1:0] startup_cycles_i = '0;
  logic             halt_o, clk_cpu_en_o, clk_io_en_o, clk_adc_en_o, clk_tmr_en_o, osc_en_o;
  logic             wake_done_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  sleep_pwr_ctrl #(.CNT_W(CNT_W)) dut (.*);

  function automatic logic [4:0] doms();
    return {clk_cpu_en_o, clk_io_en_o, clk_adc_en_o, clk_tmr_en_o, osc_en_o};
  endfunction

  function automatic bit exp_valid(logic [2:0] m, logic x);
    if (m == 3'b100 || m == 3'b101) return 1'b0;
    if (m[2]) return x;
    return 1'b1;
  endfunction

  function automatic logic [4:0] exp_dom(logic [2:0] m);
    case (m)
      3'b000:  return 5'b01111;
      3'b001:  return 5'b00111;
      3'b010:  return 5'b00000;
      3'b011:  return 5'b00010;
      3'b110:  return 5'b00001;
      3'b111:  return 5'b00011;
      default: return 5'b11111;
    endcase
  endfunction

  function automatic int exp_su(logic [2:0] m, int n);
    if (m == 3'b000 || m == 3'b001) return 0;
    if (m[2]) return 6;
    return n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk(cfg_rdata_o == v, "R2 cfg readback", cfg_rdata_o, v);
  endtask

  // one sleep attempt; returns after wake or after a rejected strobe
  task automatic trial(logic [7:0] cfg, logic x, int n);
    bit enter;
    int s, cnt;
    enter = cfg[7] && exp_valid(cfg[6:4], x);
    s = exp_su(cfg[6:4], n);
    xtal_sel_i = x;
    startup_cycles_i = CNT_W'(n);
    write_cfg(cfg);
    sleep_strobe_i = 1'b1;
    @(negedge clk_i);
    sleep_strobe_i = 1'b0;
    if (!cfg[7])
      chk(!halt_o, "R3 strobe with flag clear", halt_o, 0);
    else if (cfg[6:4] == 3'b100 || cfg[6:4] == 3'b101)
      chk(!halt_o, "R5 reserved code", halt_o, 0);
    else if (cfg[6] && !x)
      chk(!halt_o, "R6 crystal-only mode", halt_o, 0);
    else
      chk(halt_o, "R4 enter sleep", halt_o, 1);
    if (!enter) begin
      chk(doms() == 5'b11111, "R12 run clocks", doms(), 5'h1f);
      return;
    end
    chk(doms() == exp_dom(cfg[6:4]), "R7 sleep domains", doms(), exp_dom(cfg[6:4]));
    sleep_strobe_i = 1'b1;
    @(negedge clk_i);
    sleep_strobe_i = 1'b0;
    @(negedge clk_i);
    chk(halt_o && doms() == exp_dom(cfg[6:4]), "R10 strobe while asleep",
        {halt_o, doms()}, {1'b1, exp_dom(cfg[6:4])});
    irq_wake_i = 1'b1;
    @(negedge clk_i);
    irq_wake_i = 1'b0;
    if (s > 0) chk(osc_en_o, "R12 osc during start-up", osc_en_o, 1);
    if (s == 0) chk(doms() == 5'b11111, "R12 halt clocks", doms(), 5'h1f);
    cnt = 0;
    while (halt_o && cnt < 100000) begin
      cnt++;
      @(negedge clk_i);
    end
    chk(cnt == s + 4, "R8 wake latency", cnt, s + 4);
    chk(wake_done_o, "R9 done pulse", wake_done_o, 1);
    @(negedge clk_i);
    chk(!wake_done_o, "R9 done single", wake_done_o, 0);
    chk(cfg_rdata_o == cfg, "R11 flag kept", cfg_rdata_o, cfg);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(cfg_rdata_o == 8'h00 && !halt_o && !wake_done_o && doms() == 5'h1f,
        "R1 reset state", {cfg_rdata_o, halt_o, wake_done_o, doms()}, 15'h1f);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cfg_rdata_o == 8'h00 && !halt_o && doms() == 5'h1f, "R1 after reset",
        {cfg_rdata_o, halt_o, doms()}, 6'h1f);

    // R10: interrupt while running
    irq_wake_i = 1'b1;
    @(negedge clk_i);
    irq_wake_i = 1'b0;
    @(negedge clk_i);
    chk(!halt_o && !wake_done_o, "R10 irq in run", halt_o, 0);

    // directed corners
    trial(8'h0A, 1'b1, 5);            // R3 flag clear
    trial(8'hC3, 1'b1, 5);            // R5 code 100
    trial(8'hD0, 1'b1, 5);            // R5 code 101
    trial(8'hE0, 1'b0, 5);            // R6 standby w/o crystal
    trial(8'hF0, 1'b0, 5);            // R6 ext standby w/o crystal
    trial(8'hE0, 1'b1, 9);            // R6 standby with crystal
    trial(8'hF5, 1'b1, 9);
    trial(8'h80, 1'b0, 9);            // idle
    trial(8'h90, 1'b0, 9);            // ADC noise reduction
    trial(8'hA0, 1'b0, 0);            // power-down, zero start-up
    trial(8'hA0, 1'b0, 1);
    trial(8'hB7, 1'b0, 13);           // power-save

    // R11: repeated strobe without rewriting the register
    sleep_strobe_i = 1'b1;
    @(negedge clk_i);
    sleep_strobe_i = 1'b0;
    chk(halt_o, "R11 re-enter sleep", halt_o, 1);
    irq_wake_i = 1'b1;
    @(negedge clk_i);
    irq_wake_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(!halt_o, "R11 wake again", halt_o, 0);

    for (int i = 0; i < 60; i++) begin
      logic [7:0] c;
      c = 8'($urandom);
      if ($urandom_range(0, 3) != 0) c[7] = 1'b1;
      trial(c, 1'($urandom), $urandom_range(0, 20));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule